// File: doc/BRIEF.md
# Dual-Clock Dual-Data Flip-Flop

This block is a single storage element with two independent write ports. Each port has its own data input and its own clock. A rising edge on the first clock loads the first data word into the output. A rising edge on the second clock loads the second data word. The two clocks have no phase relation to each other. Rising edges of the two clocks are assumed to be separated by a guaranteed minimum interval. If two edges come closer than that, the output is undefined.

The block contains only edge-triggered registers and plain gates, so static timing analysis can handle it as usual. There are no latches, no pulse shapers and no delay chains. Each port owns one register. That register stores its port's data XOR-ed with the other port's register. The output is the XOR of the two registers. A write on either port therefore sets the output directly to that port's data. The reset input is asynchronous and clears both registers. Its polarity is chosen by a parameter.

Top module: `twin_port_flop`

## Requirements
- R1: While reset is active, `q_o` is all zeros. Reset acts at once, without any clock edge, and clock edges that arrive during reset do not change this.
- R2: After a rising edge of `ck1_i`, `q_o` equals the value `d1_i` had at that edge.
- R3: After a rising edge of `ck2_i`, `q_o` equals the value `d2_i` had at that edge.
- R4: Falling clock edges, and changes on `d1_i` or `d2_i` with no rising edge on the matching clock, leave `q_o` unchanged.
- R5: The data input of the idle port has no effect on a write: the result of a `ck1_i` write does not depend on `d2_i`, and the result of a `ck2_i` write does not depend on `d1_i`.
- R6: Reset polarity is set by `RST_POL`. With `RST_ACT_HIGH`, reset is active when `rst_i` is 1. With `RST_ACT_LOW`, reset is active when `rst_i` is 0.
- R7: All `WIDTH` bits are stored independently. Any pattern can be written and read back unchanged.
- R8: Any sequence of writes gives the correct result, including repeated writes on the same port and alternation between the ports. The output always shows the data of the most recent write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ck1_i | input | 1 | Clock of write port 1 (rising edge active) |
| d1_i | input | WIDTH | Data loaded on a rising edge of ck1_i |
| ck2_i | input | 1 | Clock of write port 2 (rising edge active) |
| d2_i | input | WIDTH | Data loaded on a rising edge of ck2_i |
| rst_i | input | 1 | Asynchronous reset, polarity set by RST_POL |
| q_o | output | WIDTH | Stored value |

## Verification
The bench builds two instances that are driven from the same clocks and data. The first uses `WIDTH` = 8 and an active-high reset, so each write can use a distinct multi-bit pattern and a single-bit coupling error shows up. The second uses `WIDTH` = 1 and an active-low reset driven with the inverted reset, so both reset polarities are exercised by the same sequences. Clock pulses are kept short and spaced well apart, so the separation assumption always holds and every result is defined.

// File: rtl/twin_flop_pkg.sv
`timescale 1ns/1ps
package twin_flop_pkg;

    typedef enum logic {
        RST_ACT_HIGH = 1'b0,
        RST_ACT_LOW  = 1'b1
    } rst_pol_e;

endpackage

// File: rtl/twin_rst_sel.sv
`timescale 1ns/1ps
module twin_rst_sel
    import twin_flop_pkg::*;
#(
    parameter rst_pol_e RST_POL = RST_ACT_HIGH
) (
    input  logic rst_i,
    output logic rst_act_o
);

    generate
        if (RST_POL == RST_ACT_LOW) begin : g_low
            assign rst_act_o = ~rst_i;
        end else begin : g_high
            assign rst_act_o = rst_i;
        end
    endgenerate

endmodule

// File: rtl/twin_port_reg.sv
`timescale 1ns/1ps
module twin_port_reg #(
    parameter int WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_act_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [WIDTH-1:0] peer_i,
    output logic [WIDTH-1:0] share_o
);

    typedef struct packed {
        logic [WIDTH-1:0] share;
    } port_state_t;

    port_state_t st_d, st_q;

    // Store this port's data folded with the peer share, so that
    // share ^ peer equals the written data right after the edge.
    always_comb begin
        st_d       = st_q;
        st_d.share = wr_data_i ^ peer_i;
    end

    always_ff @(posedge clk_i or posedge rst_act_i) begin
        if (rst_act_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign share_o = st_q.share;

endmodule

// File: rtl/twin_flop_combine.sv
`timescale 1ns/1ps
module twin_flop_combine #(
    parameter int WIDTH = 1
) (
    input  logic [WIDTH-1:0] share_a_i,
    input  logic [WIDTH-1:0] share_b_i,
    output logic [WIDTH-1:0] q_o
);

    assign q_o = share_a_i ^ share_b_i;

endmodule

// File: rtl/twin_port_flop.sv
`timescale 1ns/1ps
module twin_port_flop
    import twin_flop_pkg::*;
#(
    parameter int       WIDTH   = 8,
    parameter rst_pol_e RST_POL = RST_ACT_HIGH
) (
    input  logic             ck1_i,
    input  logic [WIDTH-1:0] d1_i,
    input  logic             ck2_i,
    input  logic [WIDTH-1:0] d2_i,
    input  logic             rst_i,
    output logic [WIDTH-1:0] q_o
);

    logic             rst_act;
    logic [WIDTH-1:0] share_a;
    logic [WIDTH-1:0] share_b;

    twin_rst_sel #(.RST_POL(RST_POL)) u_rst (
        .rst_i     (rst_i),
        .rst_act_o (rst_act)
    );

    twin_port_reg #(.WIDTH(WIDTH)) u_port_a (
        .clk_i     (ck1_i),
        .rst_act_i (rst_act),
        .wr_data_i (d1_i),
        .peer_i    (share_b),
        .share_o   (share_a)
    );

    twin_port_reg #(.WIDTH(WIDTH)) u_port_b (
        .clk_i     (ck2_i),
        .rst_act_i (rst_act),
        .wr_data_i (d2_i),
        .peer_i    (share_a),
        .share_o   (share_b)
    );

    twin_flop_combine #(.WIDTH(WIDTH)) u_combine (
        .share_a_i (share_a),
        .share_b_i (share_b),
        .q_o       (q_o)
    );

    // Checker state: the data seen at each port's last rising edge.
    // Checks assume no edge of the other clock inside a high phase.
    logic [WIDTH-1:0] cap1_q, cap2_q;
    logic             seen1_q, seen2_q;

    always_ff @(posedge ck1_i or posedge rst_act) begin
        if (rst_act) begin
            cap1_q  <= '0;
            seen1_q <= 1'b0;
        end else begin
            cap1_q  <= d1_i;
            seen1_q <= 1'b1;
        end
    end

    always_ff @(posedge ck2_i or posedge rst_act) begin
        if (rst_act) begin
            cap2_q  <= '0;
            seen2_q <= 1'b0;
        end else begin
            cap2_q  <= d2_i;
            seen2_q <= 1'b1;
        end
    end

    // R1
    rst_zero_ck1_chk: assert property (@(posedge ck1_i) rst_act |-> (q_o == '0));

    // R1
    rst_zero_ck2_chk: assert property (@(posedge ck2_i) rst_act |-> (q_o == '0));

    // R2
    port1_write_chk: assert property (@(negedge ck1_i) disable iff (rst_act || !seen1_q)
        q_o == cap1_q);

    // R3
    port2_write_chk: assert property (@(negedge ck2_i) disable iff (rst_act || !seen2_q)
        q_o == cap2_q);

endmodule

// File: tb/twin_port_flop_tb_top.sv
`timescale 1ns/1ps
module twin_port_flop_tb_top;
    import twin_flop_pkg::*;

    localparam int W = 8;
    localparam int NVEC = 12;

    // {port select (0 = port 1, 1 = port 2), d1, d2}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'hA5, 8'h3C},
        {1'b0, 8'h5A, 8'hFF},
        {1'b1, 8'h00, 8'h81},
        {1'b1, 8'hFF, 8'h7E},
        {1'b0, 8'h00, 8'h12},
        {1'b1, 8'h34, 8'hFF},
        {1'b0, 8'hFF, 8'h00},
        {1'b1, 8'hFF, 8'h00},
        {1'b0, 8'h01, 8'h80},
        {1'b0, 8'h80, 8'h01},
        {1'b1, 8'h55, 8'hAA},
        {1'b0, 8'hC3, 8'hAA}
    };

    logic         clk = 1'b0;
    logic         ck1 = 1'b0, ck2 = 1'b0;
    logic [W-1:0] d1 = '0, d2 = '0;
    logic         rst = 1'b1;
    logic         rst_n;
    logic [W-1:0] q;
    logic [0:0]   q_lo;
    logic [W-1:0] exp_q = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    assign rst_n = ~rst;

    always #2.5 clk = ~clk;

    twin_port_flop #(.WIDTH(W), .RST_POL(RST_ACT_HIGH)) dut_i (
        .ck1_i (ck1), .d1_i (d1), .ck2_i (ck2), .d2_i (d2),
        .rst_i (rst), .q_o (q)
    );

    twin_port_flop #(.WIDTH(1), .RST_POL(RST_ACT_LOW)) dut_lo_i (
        .ck1_i (ck1), .d1_i (d1[0:0]), .ck2_i (ck2), .d2_i (d2[0:0]),
        .rst_i (rst_n), .q_o (q_lo)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic check_both(input string req);
        check(req, q, exp_q);
        check({req, " narrow"}, {{(W-1){1'b0}}, q_lo}, {{(W-1){1'b0}}, exp_q[0]});
    endtask

    task automatic do_write(input logic sel, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk); d1 = a; d2 = b;
        @(posedge clk); if (sel) ck2 = 1'b1; else ck1 = 1'b1;
        @(posedge clk); ck1 = 1'b0; ck2 = 1'b0;
        @(posedge clk);
        exp_q = sel ? b : a;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, and clock edges during reset are ignored
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_q = '0;
        check_both("R1 reset state R6");
        @(posedge clk); d1 = 8'hEE; d2 = 8'h77;
        @(posedge clk); ck1 = 1'b1;
        @(posedge clk); ck1 = 1'b0;
        @(posedge clk); ck2 = 1'b1;
        @(posedge clk); ck2 = 1'b0;
        @(negedge clk);
        check_both("R1 edges during reset");
        @(posedge clk); rst = 1'b0;
        @(negedge clk);
        check_both("R1 after release");

        // R2 R3 R5 R7 R8: vector table
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
            check_both(VEC[i][16] ? "R3 R5 R7 R8 vector" : "R2 R5 R7 R8 vector");
        end

        // R4: data changes with no edge are ignored
        @(posedge clk); d1 = ~exp_q; d2 = exp_q ^ 8'h0F;
        @(posedge clk);
        @(negedge clk);
        check_both("R4 data change no edge");

        // R4: data change while ck1 high, then falling edge
        @(posedge clk); d1 = 8'h69;
        @(posedge clk); ck1 = 1'b1;
        @(posedge clk); d1 = 8'h96;
        @(posedge clk); ck1 = 1'b0;
        exp_q = 8'h69;
        @(negedge clk);
        check_both("R4 falling edge ck1");
        @(posedge clk); d2 = 8'h3A;
        @(posedge clk); ck2 = 1'b1;
        @(posedge clk); d2 = 8'hC5;
        @(posedge clk); ck2 = 1'b0;
        exp_q = 8'h3A;
        @(negedge clk);
        check_both("R4 falling edge ck2");

        // R8: random write sequences
        for (int k = 0; k < 300; k++) begin
            logic         s;
            logic [W-1:0] a, b;
            s = 1'($urandom_range(0, 1));
            a = W'($urandom);
            b = W'($urandom);
            do_write(s, a, b);
            check_both(s ? "R3 R8 random" : "R2 R8 random");
        end

        // R1: asynchronous reset with no clock edge
        do_write(1'b0, 8'hF0, 8'h0F);
        check_both("R2 before reset");
        @(posedge clk); #1 rst = 1'b1;
        #1;
        exp_q = '0;
        check_both("R1 async reset");
        @(posedge clk); rst = 1'b0;
        @(negedge clk);
        check_both("R1 held after release");

        do_write(1'b1, 8'h11, 8'hDB);
        check_both("R3 after reset");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule